// File: doc/BRIEF.md
# Floating-Point Register-List Transfer Sequencer

This block moves a chosen subset of eight 96-bit floating-point registers to or from memory in one sequence. A start pulse captures an 8-bit selection mask, a direction and an addressing form. The mask is either a static list field or the low byte of one of eight integer registers. The block then visits each register position in turn. For every selected register it moves three 32-bit words over a request/acknowledge memory port.

Post-increment sequences walk positions upward from a base address. Predecrement sequences walk positions downward and place each register below the base. Data is copied bit for bit, and no status is updated. A fault reported on any beat ends the sequence at once. The enclosing unit supplies the base address and the integer-register low bytes, and it owns the register file through a read-index/write-strobe interface.

Top module: `fp_list_xfer`

## Requirements
- R1: With `to_mem_i`=1, register contents are written to memory (`mem_we_o`=1, data taken from the register file) and no register is written. With `to_mem_i`=0, words are read from memory into registers.
- R2: With `dyn_mask_i`=1, the selection mask is byte `dyn_sel_i` of `int_low_i`, that is bits [8*sel+7 : 8*sel]. Otherwise the mask is `list_mask_i`. Bit r of the mask selects register r.
- R3: With `post_incr_i`=1, positions are visited from register 0 up to register 7. With `post_incr_i`=0 (predecrement), they are visited from register 7 down to register 0.
- R4: Each selected register takes three beats at consecutive word addresses. In post-increment form, the first beat is at `base_addr_i` and each beat adds 4, carrying register word slots 0,1,2. In predecrement form, the first beat is at `base_addr_i`-4 and each beat subtracts 4, carrying slots 2,1,0. Slot k is register bits [95-32k : 64-32k].
- R5: Unselected positions issue no request. When every beat is acknowledged in the cycle it is requested, `done_o` is first seen high after 9+3N rising edges, counting the edge that samples `start_i` as the first. N is the number of selected registers, so an empty mask finishes after 9 edges with no request. Each beat that waits L cycles adds L cycles.
- R6: A register being loaded is written exactly once, with all 96 bits, in the cycle its third beat is acknowledged without fault.
- R7: A beat acknowledged with `mem_err_i`=1 ends the sequence. No further request is made, the register in progress is not written, and registers completed earlier keep their new values.
- R8: `done_o` is a one-cycle pulse that ends the sequence. `err_o` is high with it exactly when a fault ended the sequence. `busy_o` is low in the following cycle.
- R9: `start_i` and the mode, mask and direction inputs are ignored while a sequence is in progress.
- R10: After reset, `busy_o`, `done_o`, `err_o`, `mem_req_o` and `fpr_wr_en_o` are low.
- R11: An unacknowledged request stays asserted with unchanged address, direction and register index until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a sequence (sampled when idle) |
| to_mem_i | input | 1 | 1: registers to memory, 0: memory to registers |
| post_incr_i | input | 1 | 1: post-increment form, 0: predecrement form |
| dyn_mask_i | input | 1 | Take the mask from an integer register low byte |
| dyn_sel_i | input | 3 | Integer register index for the dynamic mask |
| list_mask_i | input | 8 | Static register mask |
| int_low_i | input | 64 | Low bytes of the eight integer registers |
| base_addr_i | input | 32 | Starting address |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | Beat is a write |
| mem_addr_o | output | 32 | Beat byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Beat acknowledge |
| mem_err_i | input | 1 | Fault, valid with acknowledge |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| fpr_rd_idx_o | output | 3 | Register file read index |
| fpr_rd_data_i | input | 96 | Register file read data |
| fpr_wr_en_o | output | 1 | Register file write strobe |
| fpr_wr_idx_o | output | 3 | Register file write index |
| fpr_wr_data_o | output | 96 | Register file write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished (one cycle) |
| err_o | output | 1 | Sequence ended by a fault (with done) |

## Verification
The hardest case to reach from the ports is a fault that lands mid-list. The faulting beat may be the first, middle or last word of a register, and some registers before it have already been loaded. The outcome then depends on the scan direction and on exactly which beat faulted. The stimulus places the fault on every beat ordinal of several masks, in both forms and both directions, with a one-cycle acknowledge delay. The bench then compares the partial transaction log and the partly updated register file against a model built from the requirements. Separate runs sweep every static mask with zero-wait memory and check the cycle count, and other runs drive changed inputs and a second start pulse while the sequence is busy.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_XFER = 2'd2,
    ST_DONE = 2'd3
  } fpx_state_e;
endpackage

// File: rtl/fpx_mask_sel.sv
module fpx_mask_sel #(
  parameter int NREG   = 8,
  parameter int IREG_N = 8,
  localparam int SEL_W = (IREG_N > 1) ? $clog2(IREG_N) : 1
) (
  input  logic                   dyn_i,
  input  logic [SEL_W-1:0]       sel_i,
  input  logic [NREG-1:0]        list_i,
  input  logic [IREG_N*NREG-1:0] low_i,
  output logic [NREG-1:0]        mask_o
);
  always_comb begin
    if (dyn_i) mask_o = low_i[int'(sel_i)*NREG +: NREG];
    else       mask_o = list_i;
  end
endmodule

// File: rtl/fpx_seq_ctrl.sv
module fpx_seq_ctrl
  import fpx_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int BEATS  = 3,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 32,
  localparam int IDX_W  = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NREG-1:0]   mask_i,
  input  logic              to_mem_i,
  input  logic              post_incr_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic              ack_i,
  input  logic              err_i,
  output logic              xfer_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [BEAT_W-1:0] slot_o,
  output logic              last_beat_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(WORD_W / 8);
  localparam logic [IDX_W-1:0]  IDX_TOP  = IDX_W'(NREG - 1);
  localparam logic [BEAT_W-1:0] BEAT_TOP = BEAT_W'(BEATS - 1);

  fpx_state_e        state_q;
  logic [NREG-1:0]   mask_q;
  logic              to_mem_q, post_q, err_q;
  logic [IDX_W-1:0]  idx_q, idx_nxt;
  logic [BEAT_W-1:0] beat_q;
  logic [ADDR_W-1:0] addr_q, addr_nxt;
  logic              idx_end;

  assign idx_end  = post_q ? (idx_q == IDX_TOP) : (idx_q == '0);
  assign idx_nxt  = post_q ? idx_q + 1'b1 : idx_q - 1'b1;
  assign addr_nxt = post_q ? addr_q + STEP : addr_q - STEP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      mask_q   <= '0;
      to_mem_q <= 1'b0;
      post_q   <= 1'b0;
      err_q    <= 1'b0;
      idx_q    <= '0;
      beat_q   <= '0;
      addr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mask_q   <= mask_i;
          to_mem_q <= to_mem_i;
          post_q   <= post_incr_i;
          err_q    <= 1'b0;
          beat_q   <= '0;
          idx_q    <= post_incr_i ? '0 : IDX_TOP;
          addr_q   <= post_incr_i ? base_addr_i : base_addr_i - STEP;
          state_q  <= ST_SCAN;
        end
        ST_SCAN: begin
          if (mask_q[idx_q])  state_q <= ST_XFER;
          else if (idx_end)   state_q <= ST_DONE;
          else                idx_q   <= idx_nxt;
        end
        ST_XFER: if (ack_i) begin
          addr_q <= addr_nxt;
          if (err_i) begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end else if (beat_q == BEAT_TOP) begin
            beat_q <= '0;
            if (idx_end) state_q <= ST_DONE;
            else begin
              idx_q   <= idx_nxt;
              state_q <= ST_SCAN;
            end
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign xfer_o      = (state_q == ST_XFER);
  assign we_o        = to_mem_q;
  assign addr_o      = addr_q;
  assign idx_o       = idx_q;
  assign slot_o      = post_q ? beat_q : BEAT_TOP - beat_q;
  assign last_beat_o = (beat_q == BEAT_TOP);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign err_o       = done_o & err_q;

  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o && !ack_i |=> xfer_o && $stable(addr_o) && $stable(idx_o) && $stable(we_o));
  // R7
  fault_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o && ack_i && err_i |=> done_o && err_o && !xfer_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  // R4
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o && ack_i && !err_i && !last_beat_o |=>
      xfer_o && (addr_o == (post_q ? $past(addr_o) + STEP : $past(addr_o) - STEP)));
  // R9
  start_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> $stable(mask_q) && $stable(to_mem_q) && $stable(post_q));
endmodule

// File: rtl/fpx_beat_data.sv
module fpx_beat_data #(
  parameter int WORD_W = 32,
  parameter int BEATS  = 3,
  localparam int REG_W  = WORD_W * BEATS,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BEAT_W-1:0] slot_i,
  input  logic              capture_i,
  input  logic [WORD_W-1:0] rdata_i,
  input  logic [REG_W-1:0]  rd_reg_i,
  output logic [WORD_W-1:0] wdata_o,
  output logic [REG_W-1:0]  asm_o
);
  logic [WORD_W-1:0] hold_q [BEATS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < BEATS; k++) hold_q[k] <= '0;
    end else if (capture_i) begin
      for (int k = 0; k < BEATS; k++)
        if (slot_i == BEAT_W'(k)) hold_q[k] <= rdata_i;
    end
  end

  // slot 0 is the most significant word
  always_comb begin
    wdata_o = '0;
    for (int k = 0; k < BEATS; k++) begin
      asm_o[REG_W-1-WORD_W*k -: WORD_W] =
        (capture_i && slot_i == BEAT_W'(k)) ? rdata_i : hold_q[k];
      if (slot_i == BEAT_W'(k)) wdata_o = rd_reg_i[REG_W-1-WORD_W*k -: WORD_W];
    end
  end
endmodule

// File: rtl/fp_list_xfer.sv
module fp_list_xfer #(
  parameter int NREG   = 8,
  parameter int IREG_N = 8,
  parameter int WORD_W = 32,
  parameter int BEATS  = 3,
  parameter int ADDR_W = 32,
  localparam int REG_W = WORD_W * BEATS,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int SEL_W = (IREG_N > 1) ? $clog2(IREG_N) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   to_mem_i,
  input  logic                   post_incr_i,
  input  logic                   dyn_mask_i,
  input  logic [SEL_W-1:0]       dyn_sel_i,
  input  logic [NREG-1:0]        list_mask_i,
  input  logic [IREG_N*NREG-1:0] int_low_i,
  input  logic [ADDR_W-1:0]      base_addr_i,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic [ADDR_W-1:0]      mem_addr_o,
  output logic [WORD_W-1:0]      mem_wdata_o,
  input  logic                   mem_ack_i,
  input  logic                   mem_err_i,
  input  logic [WORD_W-1:0]      mem_rdata_i,
  output logic [IDX_W-1:0]       fpr_rd_idx_o,
  input  logic [REG_W-1:0]       fpr_rd_data_i,
  output logic                   fpr_wr_en_o,
  output logic [IDX_W-1:0]       fpr_wr_idx_o,
  output logic [REG_W-1:0]       fpr_wr_data_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   err_o
);
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [NREG-1:0]   mask;
  logic              xfer, we, last_beat, beat_ok;
  logic [IDX_W-1:0]  idx;
  logic [BEAT_W-1:0] slot;

  fpx_mask_sel #(.NREG(NREG), .IREG_N(IREG_N)) i_mask_sel (
    .dyn_i  (dyn_mask_i),
    .sel_i  (dyn_sel_i),
    .list_i (list_mask_i),
    .low_i  (int_low_i),
    .mask_o (mask)
  );

  fpx_seq_ctrl #(.NREG(NREG), .BEATS(BEATS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mask_i      (mask),
    .to_mem_i    (to_mem_i),
    .post_incr_i (post_incr_i),
    .base_addr_i (base_addr_i),
    .ack_i       (mem_ack_i),
    .err_i       (mem_err_i),
    .xfer_o      (xfer),
    .we_o        (we),
    .addr_o      (mem_addr_o),
    .idx_o       (idx),
    .slot_o      (slot),
    .last_beat_o (last_beat),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  assign beat_ok = xfer & mem_ack_i & ~mem_err_i;

  fpx_beat_data #(.WORD_W(WORD_W), .BEATS(BEATS)) i_data (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .slot_i    (slot),
    .capture_i (beat_ok & ~we),
    .rdata_i   (mem_rdata_i),
    .rd_reg_i  (fpr_rd_data_i),
    .wdata_o   (mem_wdata_o),
    .asm_o     (fpr_wr_data_o)
  );

  assign mem_req_o    = xfer;
  assign mem_we_o     = xfer & we;
  assign fpr_rd_idx_o = idx;
  assign fpr_wr_idx_o = idx;
  assign fpr_wr_en_o  = beat_ok & ~we & last_beat;

  // R6
  wr_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fpr_wr_en_o |-> mem_req_o && !mem_we_o && mem_ack_i && !mem_err_i);
  // R6
  wr_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fpr_wr_en_o |=> !fpr_wr_en_o);
  // R1
  store_no_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !fpr_wr_en_o);
endmodule

// File: tb/test_fp_list_xfer.sv
`timescale 1ns/1ps
module test_fp_list_xfer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, to_mem = 1'b0, post = 1'b0, dyn = 1'b0;
  logic [2:0]  dsel = '0;
  logic [7:0]  list = '0;
  logic [63:0] lows = '0;
  logic [31:0] base = '0;
  logic        req, we, ack = 1'b0, merr = 1'b0;
  logic [31:0] addr, wdata, rdata;
  logic [2:0]  rd_idx, wr_idx;
  logic [95:0] rd_data, wr_data;
  logic        wr_en, busy, done, err;

  logic [95:0] fpr [8];
  logic [95:0] fpr0 [8];
  logic [31:0] mem [64];
  logic [31:0] mem0 [64];
  logic [31:0] lg_addr [32];
  logic [31:0] lg_data [32];
  logic        lg_we [32];

  int checks = 0, fails = 0, rid = 0;

  always #2.5 clk = ~clk;

  assign rd_data = fpr[rd_idx];
  assign rdata   = mem[addr[7:2]];

  fp_list_xfer i_fp_list_xfer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .to_mem_i(to_mem),
    .post_incr_i(post), .dyn_mask_i(dyn), .dyn_sel_i(dsel), .list_mask_i(list),
    .int_low_i(lows), .base_addr_i(base),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_ack_i(ack), .mem_err_i(merr), .mem_rdata_i(rdata),
    .fpr_rd_idx_o(rd_idx), .fpr_rd_data_i(rd_data),
    .fpr_wr_en_o(wr_en), .fpr_wr_idx_o(wr_idx), .fpr_wr_data_o(wr_data),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  function automatic logic [31:0] wsl(input logic [95:0] v, input int s);
    return v[95-32*s -: 32];
  endfunction

  task automatic chk(input bit ok, input string req_s, input string what,
                     input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req_s, what, act, exp);
    end
  endtask

  task automatic run(input bit dm, input bit pi, input bit dy, input logic [2:0] sl,
                     input logic [7:0] lm, input logic [63:0] lw,
                     input int lat, input int fault_at, input bit poke);
    logic [7:0]  emask;
    logic [31:0] seed, ea, ed;
    logic [95:0] efpr [8];
    logic [31:0] emem [64];
    int ord [8];
    int n, ntx, comp, k, wc, g, nlog, nwr, hold_bad, bad_a, bad_d, bad_r, bad_m;
    bit faulted, err_seen;
    logic [31:0] wait_addr;
    rid++;
    seed  = 32'hC0DE_0000 + rid * 32'h0000_9E37;
    emask = dy ? lw[sl*8 +: 8] : lm;
    for (int r = 0; r < 8; r++) begin
      fpr[r]  = {seed ^ {16'h0, 5'h0, r[2:0], 8'h0}, seed ^ {16'h1, 5'h0, r[2:0], 8'h1},
                 seed ^ {16'h2, 5'h0, r[2:0], 8'h2}};
      fpr0[r] = fpr[r];
    end
    for (int i = 0; i < 64; i++) begin
      mem[i]  = ~seed ^ (i * 32'h0101_0101);
      mem0[i] = mem[i];
    end
    @(negedge clk);
    to_mem = dm; post = pi; dyn = dy; dsel = sl; list = lm; lows = lw;
    base  = pi ? 32'h100 : 32'h160;
    start = 1'b1;
    @(posedge clk);
    k = 1; wc = 0; g = 0; nlog = 0; nwr = 0; hold_bad = 0; err_seen = 0; wait_addr = '0;
    forever begin
      @(negedge clk);
      start = 1'b0;
      if (poke && k == 4) begin
        start = 1'b1; list = ~lm; lows = ~lw; to_mem = ~dm; post = ~pi;
      end
      if (poke && k == 5) begin
        list = lm; lows = lw; to_mem = dm; post = pi;
      end
      ack = 1'b0; merr = 1'b0;
      if (done) begin err_seen = err; break; end
      if (req) begin
        if (wc > 0 && addr != wait_addr) hold_bad++;
        if (wc == lat) begin
          ack  = 1'b1;
          merr = (g == fault_at);
          if (nlog < 32) begin
            lg_addr[nlog] = addr; lg_we[nlog] = we; lg_data[nlog] = we ? wdata : rdata;
          end
          nlog++;
          if (we && !merr) mem[addr[7:2]] = wdata;
          g++; wc = 0;
        end else begin
          wait_addr = addr;
          wc++;
        end
      end
      #1;
      if (wr_en) begin fpr[wr_idx] = wr_data; nwr++; end
      @(posedge clk);
      k++;
      if (k > 3000) break;
    end
    ack = 1'b0; merr = 1'b0; start = 1'b0;
    @(negedge clk);
    chk(!done && !busy, "R8", "done pulse width / busy after done", {done, busy}, 0);

    n = 0;
    for (int p = 0; p < 8; p++) begin
      int r;
      r = pi ? p : 7 - p;
      if (emask[r]) begin ord[n] = r; n++; end
    end
    ntx = 3 * n;
    faulted = (fault_at < ntx);
    if (faulted) ntx = fault_at + 1;
    comp = faulted ? fault_at / 3 : n;

    chk(nlog == ntx, dy ? "R2" : "R7", "beat count", nlog, ntx);
    for (int r = 0; r < 8; r++) efpr[r] = fpr0[r];
    for (int i = 0; i < 64; i++) emem[i] = mem0[i];
    bad_a = 0; bad_d = 0;
    for (int t = 0; t < ntx && t < nlog && t < 32; t++) begin
      int r, b, s;
      r  = ord[t / 3]; b = t % 3;
      s  = pi ? b : 2 - b;
      ea = pi ? 32'h100 + 4 * t : 32'h160 - 4 * (t + 1);
      ed = dm ? wsl(fpr0[r], s) : mem0[ea[7:2]];
      if (lg_addr[t] != ea) bad_a++;
      if (lg_we[t] != dm || lg_data[t] != ed) bad_d++;
      if (!(faulted && t == fault_at)) begin
        if (dm) emem[ea[7:2]] = ed;
        else if (t / 3 < comp) efpr[r][95-32*s -: 32] = ed;
      end
    end
    chk(bad_a == 0, pi ? "R3" : "R4", "address/order mismatches", bad_a, 0);
    chk(bad_d == 0, "R1", "beat direction/data mismatches", bad_d, 0);
    bad_r = 0; bad_m = 0;
    for (int r = 0; r < 8; r++) if (fpr[r] != efpr[r]) bad_r++;
    for (int i = 0; i < 64; i++) if (mem[i] != emem[i]) bad_m++;
    chk(bad_r == 0, "R6", "register file mismatches", bad_r, 0);
    chk(bad_m == 0, "R1", "memory mismatches", bad_m, 0);
    chk(nwr == (dm ? 0 : comp), "R6", "register write strobes", nwr, dm ? 0 : comp);
    chk(err_seen == faulted, "R7", "err at done", err_seen, faulted);
    if (!faulted) chk(k == 9 + n * 3 * (lat + 1), "R5", "cycles to done", k, 9 + n * 3 * (lat + 1));
    if (lat > 0) chk(hold_bad == 0, "R11", "request hold", hold_bad, 0);
    if (poke) chk(nlog == ntx && bad_a == 0 && bad_d == 0, "R9", "busy start ignored", bad_a + bad_d, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired act=%0d exp=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < 8; r++) fpr[r] = '0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R10
    chk(!busy && !done && !err && !req && !wr_en, "R10", "reset outputs",
        {busy, done, err, req, wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // exhaustive static masks, zero-wait memory
    for (int m = 0; m < 256; m++)
      for (int d = 0; d < 2; d++)
        for (int p = 0; p < 2; p++)
          run(d[0], p[0], 1'b0, 3'd0, m[7:0], 64'h0, 0, 99, 1'b0);

    // R2 dynamic mask from each integer register
    for (int s = 0; s < 8; s++)
      for (int j = 0; j < 4; j++) begin
        logic [63:0] lw;
        logic [7:0]  mk;
        mk = 8'h5A ^ (8'h27 * j[7:0]) ^ s[7:0];
        lw = 64'h9C4F_1B72_E0D3_8A65 ^ {8{8'h11 * j[7:0]}};
        lw[s*8 +: 8] = mk;
        run(j[0], j[1], 1'b1, s[2:0], ~mk, lw, 0, 99, 1'b0);
      end

    // R7 fault on every beat ordinal
    for (int mi = 0; mi < 3; mi++)
      for (int d = 0; d < 2; d++)
        for (int p = 0; p < 2; p++) begin
          logic [7:0] mk;
          int nb;
          mk = (mi == 0) ? 8'h81 : (mi == 1) ? 8'hFF : 8'h24;
          nb = 3 * $countones(mk);
          for (int f = 0; f < nb; f++)
            run(d[0], p[0], 1'b0, 3'd0, mk, 64'h0, 1, f, 1'b0);
        end

    // R11 slow memory
    for (int l = 2; l < 4; l++)
      for (int p = 0; p < 2; p++) begin
        run(1'b0, p[0], 1'b0, 3'd0, 8'hA5, 64'h0, l, 99, 1'b0);
        run(1'b1, p[0], 1'b0, 3'd0, 8'h3C, 64'h0, l, 99, 1'b0);
      end

    // R9 start and inputs changed while busy
    for (int p = 0; p < 2; p++)
      for (int d = 0; d < 2; d++)
        run(d[0], p[0], 1'b0, 3'd0, 8'h96, 64'h0, 0, 99, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule